// File: doc/BRIEF.md
# Multi-Mode 24-Bit Timer/Counter

This peripheral holds one 24-bit up-counter behind a small bank of 32-bit registers with byte-lane writes. The count rate comes from a prescaler. It can run on every system clock, on every 2^(1+k) system clocks for a 3-bit divider setting k, or on each cycle in which an external count-enable input is high.

One control field selects how the counter behaves. In interval mode it counts up to compare A, then either holds there or restarts from zero. In pulse mode it toggles an output flip-flop at compare A and again at compare B, and it restarts at compare B. In watchdog mode it restarts when it reaches compare A. In the disabled mode it stays still.

Every trip event sets a sticky status bit. If the trip's own enable is set, the event also raises the interrupt line. Any write to the lowest byte of the status register clears all status bits and drops the interrupt. Software reads the counter through the bus.

Top module: `tmr24_top`

## Requirements
- R1: After reset the control, status, mode and divider registers read 0, both compare registers read 0x00FFFFFF, the counter reads 0 and irq is low. Unmapped word offsets such as 0x14 read 0. Read data appears on bus_rdata one cycle after bus_rd and holds while bus_rd is low.
- R2: Register write rules:
  - Control (0x00): bit 4 is forced to 0 on a write.
  - Compare A (0x08) and compare B (0x0C): only byte lanes 0 to 2 are stored.
  - Divider (0x20): only bits 2:0 are kept.
  - Interval-mode register (0x10): bit 15 is the interval interrupt enable and bit 0 is zero-clear.
  - Pulse-mode register (0x30): bit 15 is the B interrupt enable, bit 14 is the A interrupt enable and bit 0 is the flip-flop initial value.
  - Watchdog-mode register (0x40): bit 15 is the interrupt enable and bit 7 is the watchdog disable.
  - Counter register (0xF0): reads the counter zero-extended.
- R3: A write to control with bit 7 (count enable) at 0 and bit 5 (counter reset enable) at 1 clears the counter to 0. A write with both bits at 0 stops the counter at its current value.
- R4: The counter advances every system clock when bit 6 (divider enable) and bit 2 (external select) are both 0. It advances every 2^(1+k) clocks when bit 6 is 1, where k is the divider field. It advances on each clock with ext_tick high when bit 2 is 1. The first step comes one count period after the enabling write.
- R5: In interval mode (control bits 1:0 = 0) with count enable set, the count rises to compare A and sets status bit 0. With zero-clear at 0 it then holds at compare A.
- R6: In interval mode with zero-clear at 1, the step that would reach compare A loads 0 instead. The count therefore cycles 0 to compare A minus 1.
- R7: In pulse mode (bits 1:0 = 1):
  - The step onto compare A toggles ff_out and sets status bit 1.
  - The step onto compare B toggles ff_out, sets status bit 2 and loads 0.
- R8: In watchdog mode (bits 1:0 = 2) the counter stops only when count enable is 0 and the watchdog disable bit is 1.
- R9: In watchdog mode the step onto compare A sets status bit 3 and loads 0.
- R10: In the disabled mode (bits 1:0 = 3) the counter never changes, whatever count enable holds.
- R11: Interrupt and status behaviour:
  - irq rises at a trip only when that trip's enable bit is set.
  - Status bits are set whatever the enables hold.
  - A write to status (0x04) with byte lane 0 clears all status bits and irq. A write using other lanes only changes neither.
- R12: A reset loads ff_out with the flip-flop initial-value bit as it stood before the reset, while the register itself clears to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register word |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| ext_tick | input | 1 | External count enable, one step per high cycle |
| irq | output | 1 | Interrupt, held until status is cleared |
| ff_out | output | 1 | Pulse flip-flop output |

## Verification
A register write takes effect on the edge that samples it. The first count step lands one count period later, so after the enabling write and D further edges the counter holds floor(D/P) steps, before any trip rule applies. Status, irq and ff_out change on the same edge as the trip step. Read data arrives one edge after the read strobe and returns the counter value from before that edge. The bench drives on falling edges and samples irq and ff_out right after the D waits. It then issues reads whose capture edge is counted in, and each scenario is chosen so that no trip falls on that extra edge.

// File: rtl/tmr24_pkg.sv
package tmr24_pkg;
  localparam int ADDR_W = 8;
  localparam int ST_W   = 4;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'd0,
    MODE_PULSE    = 2'd1,
    MODE_WDOG     = 2'd2,
    MODE_OFF      = 2'd3
  } tmr_mode_e;

  // word indices (byte offset / 4)
  localparam logic [ADDR_W-3:0] W_CTRL  = 6'h00;
  localparam logic [ADDR_W-3:0] W_STAT  = 6'h01;
  localparam logic [ADDR_W-3:0] W_CMPA  = 6'h02;
  localparam logic [ADDR_W-3:0] W_CMPB  = 6'h03;
  localparam logic [ADDR_W-3:0] W_IMODE = 6'h04;
  localparam logic [ADDR_W-3:0] W_DIV   = 6'h08;
  localparam logic [ADDR_W-3:0] W_PMODE = 6'h0C;
  localparam logic [ADDR_W-3:0] W_WMODE = 6'h10;
  localparam logic [ADDR_W-3:0] W_COUNT = 6'h3C;

  // control bits written through lane 0 keep everything but bit 4
  localparam logic [7:0] CTRL_KEEP = 8'hEF;
endpackage

// File: rtl/tmr24_regs.sv
module tmr24_regs import tmr24_pkg::*; #(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ST_W-1:0]   status,
  output tmr_mode_e         mode,
  output logic              run_en,
  output logic              div_en,
  output logic              ext_sel,
  output logic [DIV_W-1:0]  div,
  output logic [CNT_W-1:0]  cmpa,
  output logic [CNT_W-1:0]  cmpb,
  output logic              iie,
  output logic              zce,
  output logic              pa_ie,
  output logic              pb_ie,
  output logic              ffi,
  output logic              wie,
  output logic              wdis,
  output logic              cnt_clr,
  output logic              st_clr
);
  localparam int LANES     = DATA_W / 8;
  localparam int CMP_LANES = CNT_W / 8;

  logic [ADDR_W-3:0] widx;
  logic [7:0]        ctrl_q;
  logic [CNT_W-1:0]  cmpa_q, cmpb_q, cmpa_n, cmpb_n;
  logic [DIV_W-1:0]  div_q;
  logic              iie_q, zce_q, pa_q, pb_q, ffi_q, wie_q, wdis_q;
  logic [DATA_W-1:0] rmux;
  logic              lo_wr, hi_wr;

  assign widx  = addr[ADDR_W-1:2];
  assign lo_wr = wr & be[0];
  assign hi_wr = wr & be[1];

  // compare registers: only the lanes that exist in the counter width
  for (genvar b = 0; b < CMP_LANES; b++) begin : g_cmp_lane
    assign cmpa_n[b*8 +: 8] = (wr && be[b] && widx == W_CMPA) ? wdata[b*8 +: 8] : cmpa_q[b*8 +: 8];
    assign cmpb_n[b*8 +: 8] = (wr && be[b] && widx == W_CMPB) ? wdata[b*8 +: 8] : cmpb_q[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      div_q  <= '0;
      cmpa_q <= '1;
      cmpb_q <= '1;
      iie_q  <= 1'b0;
      zce_q  <= 1'b0;
      pa_q   <= 1'b0;
      pb_q   <= 1'b0;
      ffi_q  <= 1'b0;
      wie_q  <= 1'b0;
      wdis_q <= 1'b0;
    end else begin
      cmpa_q <= cmpa_n;
      cmpb_q <= cmpb_n;
      if (lo_wr) begin
        if (widx == W_CTRL)  ctrl_q <= wdata[7:0] & CTRL_KEEP;
        if (widx == W_DIV)   div_q  <= wdata[DIV_W-1:0];
        if (widx == W_IMODE) zce_q  <= wdata[0];
        if (widx == W_PMODE) ffi_q  <= wdata[0];
        if (widx == W_WMODE) wdis_q <= wdata[7];
      end
      if (hi_wr) begin
        if (widx == W_IMODE) iie_q <= wdata[15];
        if (widx == W_PMODE) begin
          pb_q <= wdata[15];
          pa_q <= wdata[14];
        end
        if (widx == W_WMODE) wie_q <= wdata[15];
      end
    end
  end

  always_comb begin
    rmux = '0;
    case (widx)
      W_CTRL:  rmux[7:0] = ctrl_q;
      W_STAT:  rmux[ST_W-1:0] = status;
      W_CMPA:  rmux[CNT_W-1:0] = cmpa_q;
      W_CMPB:  rmux[CNT_W-1:0] = cmpb_q;
      W_IMODE: begin rmux[15] = iie_q; rmux[0] = zce_q; end
      W_DIV:   rmux[DIV_W-1:0] = div_q;
      W_PMODE: begin rmux[15] = pb_q; rmux[14] = pa_q; rmux[0] = ffi_q; end
      W_WMODE: begin rmux[15] = wie_q; rmux[7] = wdis_q; end
      W_COUNT: rmux[CNT_W-1:0] = cnt;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rmux;
  end

  assign mode    = tmr_mode_e'(ctrl_q[1:0]);
  assign run_en  = ctrl_q[7];
  assign div_en  = ctrl_q[6];
  assign ext_sel = ctrl_q[2];
  assign div     = div_q;
  assign cmpa    = cmpa_q;
  assign cmpb    = cmpb_q;
  assign iie     = iie_q;
  assign zce     = zce_q;
  assign pa_ie   = pa_q;
  assign pb_ie   = pb_q;
  assign ffi     = ffi_q;
  assign wie     = wie_q;
  assign wdis    = wdis_q;
  assign cnt_clr = lo_wr && widx == W_CTRL && !wdata[7] && wdata[5];
  assign st_clr  = lo_wr && widx == W_STAT;

  logic unused_bits;
  assign unused_bits = ^{addr[1:0], be[LANES-1:CMP_LANES], wdata[DATA_W-1:CNT_W]};

  // R1: read data only moves on a read strobe
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/tmr24_prescale.sv
module tmr24_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             div_en,
  input  logic             ext_sel,
  input  logic             ext_tick,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PRE_W = 1 << DIV_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // mask has div+1 low ones: period 2^(1+div)
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (i <= int'(div));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else             pre_q <= pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
  end

  always_comb begin
    if (!run)        tick = 1'b0;
    else if (ext_sel) tick = ext_tick;
    else if (div_en)  tick = ((pre_q & mask) == mask);
    else              tick = 1'b1;
  end

  // R4: with the divider on, steps are never back to back
  p_div_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && div_en && !ext_sel) |=> (!tick || !div_en || ext_sel));
endmodule

// File: rtl/tmr24_core.sv
module tmr24_core import tmr24_pkg::*; #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  tmr_mode_e        mode,
  input  logic             run_en,
  input  logic [CNT_W-1:0] cmpa,
  input  logic [CNT_W-1:0] cmpb,
  input  logic             iie,
  input  logic             zce,
  input  logic             pa_ie,
  input  logic             pb_ie,
  input  logic             wie,
  input  logic             wdis,
  input  logic             ffi,
  input  logic             cnt_clr,
  input  logic             st_clr,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic [ST_W-1:0]  status,
  output logic             irq,
  output logic             ff
);
  logic [CNT_W-1:0] cnt_q, nxt, cnt_d;
  logic [ST_W-1:0]  st_q, st_set;
  logic             irq_q, ff_q, ev_irq, flip;

  assign nxt = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    case (mode)
      MODE_INTERVAL: run = run_en && (cnt_q != cmpa);
      MODE_PULSE:    run = run_en;
      MODE_WDOG:     run = run_en || !wdis;
      default:       run = 1'b0;
    endcase
  end

  always_comb begin
    cnt_d  = nxt;
    st_set = '0;
    ev_irq = 1'b0;
    flip   = 1'b0;
    case (mode)
      MODE_INTERVAL: if (nxt == cmpa) begin
        st_set[0] = 1'b1;
        ev_irq    = iie;
        cnt_d     = zce ? '0 : nxt;
      end
      MODE_PULSE: if (nxt == cmpa) begin
        flip      = 1'b1;
        st_set[1] = 1'b1;
        ev_irq    = pa_ie;
      end else if (nxt == cmpb) begin
        flip      = 1'b1;
        st_set[2] = 1'b1;
        ev_irq    = pb_ie;
        cnt_d     = '0;
      end
      MODE_WDOG: if (nxt == cmpa) begin
        st_set[3] = 1'b1;
        ev_irq    = wie;
        cnt_d     = '0;
      end
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      st_q  <= '0;
      irq_q <= 1'b0;
      ff_q  <= ffi;
    end else begin
      if (cnt_clr)   cnt_q <= '0;
      else if (tick) cnt_q <= cnt_d;
      st_q <= (st_clr ? '0 : st_q) | (tick ? st_set : '0);
      if (tick && ev_irq) irq_q <= 1'b1;
      else if (st_clr)    irq_q <= 1'b0;
      if (tick && flip)   ff_q <= ~ff_q;
    end
  end

  assign cnt    = cnt_q;
  assign status = st_q;
  assign irq    = irq_q;
  assign ff     = ff_q;

  // R5: interval mode parks at compare A
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_INTERVAL && cnt_q == cmpa && !cnt_clr) |=> $stable(cnt_q));
  // R10: disabled mode never counts
  p_off_r10: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF && !cnt_clr) |=> $stable(cnt_q));
  // R8: watchdog stops only with enable low and disable set
  p_wd_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_WDOG && !run_en && wdis && !cnt_clr) |=> $stable(cnt_q));
  // R3: a clearing control write zeroes the counter
  p_clr_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (cnt_q == '0));
  // R11: a status write drops irq unless a new trip lands with it
  p_irq_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (st_clr && !(tick && ev_irq)) |=> !irq_q);
endmodule

// File: rtl/tmr24_top.sv
module tmr24_top import tmr24_pkg::*; #(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                ext_tick,
  output logic                irq,
  output logic                ff_out
);
  tmr_mode_e        mode;
  logic             run_en, div_en, ext_sel, run, tick;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] cmpa, cmpb, cnt;
  logic             iie, zce, pa_ie, pb_ie, ffi, wie, wdis, cnt_clr, st_clr;
  logic [ST_W-1:0]  status;

  tmr24_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .be(bus_be), .wdata(bus_wdata),
    .wr(bus_wr), .rd(bus_rd), .rdata(bus_rdata), .cnt(cnt), .status(status),
    .mode(mode), .run_en(run_en), .div_en(div_en), .ext_sel(ext_sel), .div(div),
    .cmpa(cmpa), .cmpb(cmpb), .iie(iie), .zce(zce), .pa_ie(pa_ie), .pb_ie(pb_ie),
    .ffi(ffi), .wie(wie), .wdis(wdis), .cnt_clr(cnt_clr), .st_clr(st_clr)
  );

  tmr24_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .div_en(div_en), .ext_sel(ext_sel),
    .ext_tick(ext_tick), .div(div), .tick(tick)
  );

  tmr24_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .run_en(run_en),
    .cmpa(cmpa), .cmpb(cmpb), .iie(iie), .zce(zce), .pa_ie(pa_ie), .pb_ie(pb_ie),
    .wie(wie), .wdis(wdis), .ffi(ffi), .cnt_clr(cnt_clr), .st_clr(st_clr),
    .run(run), .cnt(cnt), .status(status), .irq(irq), .ff(ff_out)
  );
endmodule

// File: tb/tmr24_top_bench.sv
module tmr24_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        ext_tick = 1'b0;
  logic        irq, ff_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_CMPA = 8'h08, A_CMPB = 8'h0C,
                         A_IMODE = 8'h10, A_DIV = 8'h20, A_PMODE = 8'h30, A_WMODE = 8'h40,
                         A_COUNT = 8'hF0, A_HOLE = 8'h14;

  always #5 clk = ~clk;

  tmr24_top u_tmr24_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ext_tick(ext_tick),
    .irq(irq), .ff_out(ff_out)
  );

  // imode = {int enable, zero-clear}; pmode = {B enable, A enable}; wmode = {int enable, disable}
  typedef struct packed {
    logic [7:0]  ctrl;
    logic [2:0]  div;
    logic [23:0] cmpa;
    logic [23:0] cmpb;
    logic [1:0]  imode;
    logic [1:0]  pmode;
    logic [1:0]  wmode;
    logic        ext;
    logic [7:0]  wait_n;
    logic [23:0] exp_cnt;
    logic [3:0]  exp_st;
    logic        exp_irq;
    logic        exp_ff;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{8'h80, 3'd0, 24'd10,     24'hFFFFFF, 2'b10, 2'b00, 2'b00, 1'b0, 8'd5,  24'd5,  4'h0, 1'b0, 1'b0, 8'd4},  // R4 plain rate
    '{8'h80, 3'd0, 24'd10,     24'hFFFFFF, 2'b10, 2'b00, 2'b00, 1'b0, 8'd20, 24'd10, 4'h1, 1'b1, 1'b0, 8'd5},  // R5 hold
    '{8'h80, 3'd0, 24'd10,     24'hFFFFFF, 2'b11, 2'b00, 2'b00, 1'b0, 8'd23, 24'd3,  4'h1, 1'b1, 1'b0, 8'd6},  // R6 wrap
    '{8'hC0, 3'd1, 24'd100,    24'hFFFFFF, 2'b00, 2'b00, 2'b00, 1'b0, 8'd21, 24'd5,  4'h0, 1'b0, 1'b0, 8'd4},  // R4 /4
    '{8'hC0, 3'd0, 24'd100,    24'hFFFFFF, 2'b00, 2'b00, 2'b00, 1'b0, 8'd9,  24'd4,  4'h0, 1'b0, 1'b0, 8'd4},  // R4 /2
    '{8'h84, 3'd0, 24'hFFFFFF, 24'hFFFFFF, 2'b00, 2'b00, 2'b00, 1'b0, 8'd10, 24'd0,  4'h0, 1'b0, 1'b0, 8'd4},  // R4 ext low
    '{8'h84, 3'd0, 24'hFFFFFF, 24'hFFFFFF, 2'b00, 2'b00, 2'b00, 1'b1, 8'd7,  24'd7,  4'h0, 1'b0, 1'b0, 8'd4},  // R4 ext high
    '{8'h81, 3'd0, 24'd3,      24'd8,      2'b00, 2'b01, 2'b00, 1'b0, 8'd5,  24'd5,  4'h2, 1'b1, 1'b1, 8'd7},  // R7 A trip
    '{8'h81, 3'd0, 24'd3,      24'd8,      2'b00, 2'b01, 2'b00, 1'b0, 8'd10, 24'd2,  4'h6, 1'b1, 1'b0, 8'd7},  // R7 B trip
    '{8'h81, 3'd0, 24'd3,      24'd8,      2'b00, 2'b10, 2'b00, 1'b0, 8'd5,  24'd5,  4'h2, 1'b0, 1'b1, 8'd11}, // R11 gating
    '{8'h02, 3'd0, 24'd6,      24'hFFFFFF, 2'b00, 2'b00, 2'b00, 1'b0, 8'd4,  24'd4,  4'h0, 1'b0, 1'b0, 8'd8},  // R8 runs
    '{8'h02, 3'd0, 24'd6,      24'hFFFFFF, 2'b00, 2'b00, 2'b01, 1'b0, 8'd10, 24'd0,  4'h0, 1'b0, 1'b0, 8'd8},  // R8 stopped
    '{8'h82, 3'd0, 24'd6,      24'hFFFFFF, 2'b00, 2'b00, 2'b11, 1'b0, 8'd14, 24'd2,  4'h8, 1'b1, 1'b0, 8'd9},  // R9 trips
    '{8'h83, 3'd0, 24'd6,      24'hFFFFFF, 2'b00, 2'b00, 2'b00, 1'b0, 8'd10, 24'd0,  4'h0, 1'b0, 1'b0, 8'd10}, // R10 off
    '{8'h80, 3'd0, 24'd4,      24'hFFFFFF, 2'b00, 2'b00, 2'b00, 1'b0, 8'd9,  24'd4,  4'h1, 1'b0, 1'b0, 8'd11}  // R11 no enable
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    bus_addr = a; bus_wdata = d; bus_be = b; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(A_CTRL, d);  chk("R1 ctrl", d, 32'h0);
    rd(A_CMPA, d);  chk("R1 cmpa", d, 32'h00FFFFFF);
    rd(A_CMPB, d);  chk("R1 cmpb", d, 32'h00FFFFFF);
    rd(A_STAT, d);  chk("R1 status", d, 32'h0);
    rd(A_COUNT, d); chk("R1 count", d, 32'h0);
    rd(A_HOLE, d);  chk("R1 unmapped", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 write masks and lanes
    wr(A_CTRL, 32'h0000_0017, 4'hF);  rd(A_CTRL, d);  chk("R2 ctrl bit4", d, 32'h07);
    wr(A_CMPA, 32'hAB12_3456, 4'hF);  rd(A_CMPA, d);  chk("R2 cmpa lanes", d, 32'h0012_3456);
    wr(A_CMPB, 32'h0055_0000, 4'h4);  rd(A_CMPB, d);  chk("R2 cmpb lane2", d, 32'h0055_FFFF);
    wr(A_DIV, 32'hFFFF_FFFF, 4'hF);   rd(A_DIV, d);   chk("R2 divider", d, 32'h7);
    wr(A_IMODE, 32'hFFFF_FFFF, 4'hF); rd(A_IMODE, d); chk("R2 imode", d, 32'h8001);
    wr(A_PMODE, 32'hFFFF_FFFE, 4'hF); rd(A_PMODE, d); chk("R2 pmode", d, 32'hC000);
    wr(A_WMODE, 32'hFFFF_FFFF, 4'hF); rd(A_WMODE, d); chk("R2 wmode", d, 32'h8080);

    // table of scenarios
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(A_CMPA, {8'h0, VT[i].cmpa}, 4'hF);
      wr(A_CMPB, {8'h0, VT[i].cmpb}, 4'hF);
      wr(A_DIV, {29'b0, VT[i].div}, 4'hF);
      wr(A_IMODE, {16'b0, VT[i].imode[1], 14'b0, VT[i].imode[0]}, 4'hF);
      wr(A_PMODE, {16'b0, VT[i].pmode[1], VT[i].pmode[0], 14'b0}, 4'hF);
      wr(A_WMODE, {16'b0, VT[i].wmode[1], 7'b0, VT[i].wmode[0], 7'b0}, 4'hF);
      ext_tick = VT[i].ext;
      wr(A_CTRL, {24'b0, VT[i].ctrl}, 4'hF);
      repeat (VT[i].wait_n) @(negedge clk);
      chk($sformatf("R%0d vec%0d irq", VT[i].req, i), {31'b0, irq}, {31'b0, VT[i].exp_irq});
      chk($sformatf("R%0d vec%0d ff", VT[i].req, i), {31'b0, ff_out}, {31'b0, VT[i].exp_ff});
      rd(A_COUNT, d);
      chk($sformatf("R%0d vec%0d count", VT[i].req, i), d, {8'b0, VT[i].exp_cnt});
      rd(A_STAT, d);
      chk($sformatf("R%0d vec%0d status", VT[i].req, i), d, {28'b0, VT[i].exp_st});
      ext_tick = 1'b0;
    end

    // R3 stop without clear, then clear
    do_reset();
    wr(A_CMPA, 32'd1000, 4'hF);
    wr(A_CTRL, 32'h80, 4'hF);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h00, 4'hF);
    repeat (3) @(negedge clk);
    rd(A_COUNT, d); chk("R3 stop holds", d, 32'd6);
    wr(A_CTRL, 32'h20, 4'hF);
    rd(A_COUNT, d); chk("R3 clear", d, 32'd0);

    // R11 status clear by lane 0 only
    do_reset();
    wr(A_CMPA, 32'd3, 4'hF);
    wr(A_IMODE, 32'h8000, 4'hF);
    wr(A_CTRL, 32'h80, 4'hF);
    repeat (6) @(negedge clk);
    chk("R11 irq raised", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h0000_FF00, 4'h2);
    chk("R11 lane1 ignored irq", {31'b0, irq}, 32'h1);
    rd(A_STAT, d); chk("R11 lane1 ignored status", d, 32'h1);
    wr(A_STAT, 32'h0, 4'h1);
    chk("R11 irq cleared", {31'b0, irq}, 32'h0);
    rd(A_STAT, d); chk("R11 status cleared", d, 32'h0);

    // R12 flip-flop preset on reset
    do_reset();
    wr(A_PMODE, 32'h1, 4'hF);
    chk("R12 ff before reset", {31'b0, ff_out}, 32'h0);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R12 ff preset", {31'b0, ff_out}, 32'h1);
    rd(A_PMODE, d); chk("R12 pmode cleared", d, 32'h0);
    do_reset();
    chk("R12 ff preset zero", {31'b0, ff_out}, 32'h0);

    // R4 separate external pulses
    do_reset();
    wr(A_CTRL, 32'h84, 4'hF);
    for (int p = 0; p < 3; p++) begin
      ext_tick = 1'b1; @(negedge clk);
      ext_tick = 1'b0; repeat (2) @(negedge clk);
    end
    rd(A_COUNT, d); chk("R4 ext pulses", d, 32'd3);

    // R4 largest divider setting
    do_reset();
    wr(A_DIV, 32'd7, 4'hF);
    wr(A_CTRL, 32'hC0, 4'hF);
    repeat (600) @(negedge clk);
    rd(A_COUNT, d); chk("R4 divide by 256", d, 32'd2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule